// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller built from a parameterised number of 8-pin ports. Every port repeats one register bank at a fixed 0x30-byte stride. The bank holds, per pin:

- an output value;
- a two-bit drive mode;
- a pull-up disable bit;
- a synchronised input value;
- an edge-select bit;
- an interrupt-enable bit;
- a sticky event bit.

A single global control word at address 0x00 reports the port count and a core version. Its two low bits gate edge detection and select the depth of the input synchroniser.

Software reaches the registers through a simple 32-bit bus. Writes take effect on the clock edge of the cycle in which they are presented. Reads return data combinationally in the same cycle. Each port raises its own interrupt line whenever one of its enabled events is pending. The pad side exposes, for every pin, an output value, an output enable, a pull-up enable and the raw input.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every writable register is zero. All pads have output enable 0 and pull-up enable 1, and every port interrupt is 0.
- R2: The control word at address 0x00 reads the port count in bits 15:9, the core version in bits 8:2 and the two writable bits in 1:0. Port p occupies addresses p*0x30 plus these offsets: 0x04 input (read-only), 0x08 output data, 0x0C mode, 0x10 pull-up disable, 0x14 event, 0x18 interrupt enable, 0x1C force, 0x20 edge select. Each register reads back what was written.
- R3: The mode field of pin k sits at bits 2k+1:2k. Code 00 gives output enable 0 and output 0. Code 01 drives the data bit. Code 10 enables the pad only when data is 0 and drives 0. Code 11 enables the pad only when data is 1 and drives 1.
- R4: A 1 in bit k of the pull-up disable register makes the pull-up enable of pin k equal 0. A 0 makes it 1.
- R5: Control bit 1 selects a two-flop input synchroniser; 0 selects a single flop. The input register shows the synchronised value: one cycle after a pad change with one flop, two cycles after with two.
- R6: Edge-select 1 arms a rising edge and 0 arms a falling edge, compared against the synchronised input one cycle later. An event is recorded whether or not the pin's interrupt is enabled, and only while control bit 0 is 1.
- R7: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. A new event or a force in the same cycle wins over the clear. Without a write, events never drop.
- R8: While a force bit is 1, the matching event bit is set on every clock. Writing 0 to the force register stops forcing.
- R9: A port's interrupt line is high exactly when some pin of that port has both its event and its enable bit set.
- R10: Reads of unmapped offsets, and of ports at or beyond the configured count, return 0, and writes to them change nothing. Writes to the input register are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| pad_in | input | NUM_PORTS*8 | Raw pad inputs |
| pad_out | output | NUM_PORTS*8 | Pad output values |
| pad_oe | output | NUM_PORTS*8 | Pad output enables |
| pad_pu | output | NUM_PORTS*8 | Pad pull-up enables |
| port_irq | output | NUM_PORTS | One interrupt per port |

## Verification
The bench probes the exact latency from a pad change to the input register and to the event bit, for both synchroniser depths. A design with an off-by-one stage would show the new value or event one cycle early or late. It clears events while a force is held and while edges arrive, which catches a clear that wrongly beats a set. It also drives edges with detection disabled or with the opposite edge selected, which exposes spurious events. Accesses to a port beyond the configured count and to gaps in the map show up any address aliasing that would corrupt port 0.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int PINS_PER_PORT = 8;
  localparam int PORT_STRIDE   = 48;
  localparam int MAX_PORTS     = 7;

  typedef enum logic [1:0] {
    DRV_IN     = 2'b00,
    DRV_PUSH   = 2'b01,
    DRV_SINK   = 2'b10,
    DRV_SOURCE = 2'b11
  } drv_mode_e;

  typedef enum logic [3:0] {
    REG_NONE,
    REG_IN,
    REG_OUT,
    REG_MODE,
    REG_PULL,
    REG_EVENT,
    REG_IEN,
    REG_FORCE,
    REG_EDGE
  } reg_sel_e;

  // Returns {output_enable, output_value} for one pin.
  function automatic logic [1:0] pad_drive(drv_mode_e m, logic d);
    case (m)
      DRV_PUSH:   return {1'b1, d};
      DRV_SINK:   return {~d, 1'b0};
      DRV_SOURCE: return {d, 1'b1};
      default:    return 2'b00;
    endcase
  endfunction

  // Maps an in-port byte offset to a register select.
  function automatic reg_sel_e decode_off(logic [5:0] off);
    case (off)
      6'h04:   return REG_IN;
      6'h08:   return REG_OUT;
      6'h0C:   return REG_MODE;
      6'h10:   return REG_PULL;
      6'h14:   return REG_EVENT;
      6'h18:   return REG_IEN;
      6'h1C:   return REG_FORCE;
      6'h20:   return REG_EDGE;
      default: return REG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge
  import gpio_pkg::*;
#(
  parameter int W = PINS_PER_PORT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  input  logic         two_stage,
  input  logic         run,
  input  logic [W-1:0] rise_sel,
  output logic [W-1:0] in_val,
  output logic [W-1:0] hit
);

  logic [W-1:0] s1_q, s2_q, prev_q;
  logic [W-1:0] rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pad_in;
      s2_q   <= s1_q;
      prev_q <= in_val;
    end
  end

  assign in_val = two_stage ? s2_q : s1_q;
  assign rise   = in_val & ~prev_q;
  assign fall   = ~in_val & prev_q;
  assign hit    = run ? ((rise & rise_sel) | (fall & ~rise_sel)) : '0;

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int W = PINS_PER_PORT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  reg_sel_e      sel,
  input  logic          wr_en,
  input  logic [15:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [W-1:0]  in_val,
  input  logic [W-1:0]  hit,
  output logic [W-1:0]  rise_sel,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pu,
  output logic          irq
);

  localparam int MW = 2 * W;

  logic [W-1:0]  dout_q, pud_q, ev_q, ien_q, force_q, edge_q;
  logic [MW-1:0] mode_q;
  logic [W-1:0]  ev_clr;
  logic          ev_wr;

  assign ev_wr  = wr_en && (sel == REG_EVENT);
  assign ev_clr = ev_wr ? wdata[W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      pud_q   <= '0;
      ien_q   <= '0;
      force_q <= '0;
      edge_q  <= '0;
      mode_q  <= '0;
      ev_q    <= '0;
    end else begin
      ev_q <= (ev_q & ~ev_clr) | hit | force_q;
      if (wr_en) begin
        case (sel)
          REG_OUT:   dout_q  <= wdata[W-1:0];
          REG_MODE:  mode_q  <= wdata[MW-1:0];
          REG_PULL:  pud_q   <= wdata[W-1:0];
          REG_IEN:   ien_q   <= wdata[W-1:0];
          REG_FORCE: force_q <= wdata[W-1:0];
          REG_EDGE:  edge_q  <= wdata[W-1:0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      REG_IN:    rdata[W-1:0]  = in_val;
      REG_OUT:   rdata[W-1:0]  = dout_q;
      REG_MODE:  rdata[MW-1:0] = mode_q;
      REG_PULL:  rdata[W-1:0]  = pud_q;
      REG_EVENT: rdata[W-1:0]  = ev_q;
      REG_IEN:   rdata[W-1:0]  = ien_q;
      REG_FORCE: rdata[W-1:0]  = force_q;
      REG_EDGE:  rdata[W-1:0]  = edge_q;
      default:   rdata = '0;
    endcase
  end

  for (genvar k = 0; k < W; k++) begin : g_pin
    logic [1:0] drv;
    assign drv        = pad_drive(drv_mode_e'(mode_q[2*k +: 2]), dout_q[k]);
    assign pad_oe[k]  = drv[1];
    assign pad_out[k] = drv[0];

    assert_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*k +: 2] == 2'b00) |-> !pad_oe[k]);
  end

  assign pad_pu   = ~pud_q;
  assign rise_sel = edge_q;
  assign irq      = |(ev_q & ien_q);

  // Without an event write, pending events never drop.
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_wr |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  // A held force shows up in the event register on the next clock.
  assert_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q != '0) |=> ((ev_q & $past(force_q)) == $past(force_q)));

  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS    = 3,
  parameter int CORE_VERSION = 5,
  parameter int ADDR_W       = 9
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_sel,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [31:0]                     bus_wdata,
  output logic [31:0]                     bus_rdata,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_in,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_out,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_oe,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_pu,
  output logic [NUM_PORTS-1:0]            port_irq
);

  localparam int P = PINS_PER_PORT;
  localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(PORT_STRIDE);
  localparam logic [31:0] ID_WORD =
    {16'b0, 7'(NUM_PORTS), 7'(CORE_VERSION), 2'b00};

  logic [1:0]        ctrl_q;
  logic [ADDR_W-1:0] port_idx, port_off;
  reg_sel_e          off_sel;
  logic              ctrl_hit, port_hit, addr_hit;
  logic [31:0]       port_rd [NUM_PORTS];
  logic              unused_bits;

  assign port_idx = bus_addr / STRIDE_A;
  assign port_off = bus_addr % STRIDE_A;
  assign off_sel  = decode_off(port_off[5:0]);
  assign ctrl_hit = (bus_addr == '0);
  assign port_hit = (port_idx < ADDR_W'(NUM_PORTS)) && (off_sel != REG_NONE);
  assign addr_hit = ctrl_hit || port_hit;
  assign unused_bits = &{1'b0, port_off[ADDR_W-1:6], bus_wdata[31:16]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (bus_sel && bus_wr && ctrl_hit)
      ctrl_q <= bus_wdata[1:0];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    reg_sel_e   psel;
    logic [P-1:0] in_val, hit, rise_sel;

    assign psel = (bus_sel && port_idx == ADDR_W'(p)) ? off_sel : REG_NONE;

    gpio_sync_edge #(.W(P)) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pad_in    (pad_in[p*P +: P]),
      .two_stage (ctrl_q[1]),
      .run       (ctrl_q[0]),
      .rise_sel  (rise_sel),
      .in_val    (in_val),
      .hit       (hit)
    );

    gpio_port #(.W(P)) i_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (psel),
      .wr_en    (bus_wr),
      .wdata    (bus_wdata[15:0]),
      .rdata    (port_rd[p]),
      .in_val   (in_val),
      .hit      (hit),
      .rise_sel (rise_sel),
      .pad_out  (pad_out[p*P +: P]),
      .pad_oe   (pad_oe[p*P +: P]),
      .pad_pu   (pad_pu[p*P +: P]),
      .irq      (port_irq[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (ctrl_hit) bus_rdata = ID_WORD | {30'b0, ctrl_q};
      for (int p = 0; p < NUM_PORTS; p++) bus_rdata = bus_rdata | port_rd[p];
    end
  end

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !addr_hit) |-> (bus_rdata == '0));

endmodule

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;

  localparam int NP  = 3;
  localparam int VER = 5;
  localparam int AW  = 9;
  localparam int NPIN = NP * 8;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NPIN-1:0] pad_in = '0, pad_out, pad_oe, pad_pu;
  logic [NP-1:0] port_irq;

  int total = 0, bad = 0;

  gpio_bank_ctrl #(.NUM_PORTS(NP), .CORE_VERSION(VER), .ADDR_W(AW)) i_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .port_irq(port_irq));

  always #10 clk = ~clk;

  // Behavioural reference model, one entry per pin.
  int m_ctrl;
  bit m_dout[NPIN], m_pud[NPIN], m_ev[NPIN], m_ien[NPIN], m_frc[NPIN], m_edge[NPIN];
  int m_mode[NPIN];
  bit m_s1[NPIN], m_s2[NPIN], m_prev[NPIN];

  function automatic bit m_in(int i);
    return (m_ctrl & 2) ? m_s2[i] : m_s1[i];
  endfunction

  function automatic int m_read(int a);
    int p, off, v;
    if (a == 0) return (NP << 9) | (VER << 2) | m_ctrl;
    p = a / 48; off = a % 48; v = 0;
    if (p >= NP) return 0;
    for (int k = 0; k < 8; k++) begin
      int i;
      i = p * 8 + k;
      case (off)
        4:  v = v | (int'(m_in(i)) << k);
        8:  v = v | (int'(m_dout[i]) << k);
        12: v = v | (m_mode[i] << (2 * k));
        16: v = v | (int'(m_pud[i]) << k);
        20: v = v | (int'(m_ev[i]) << k);
        24: v = v | (int'(m_ien[i]) << k);
        28: v = v | (int'(m_frc[i]) << k);
        32: v = v | (int'(m_edge[i]) << k);
        default: v = 0;
      endcase
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0;
      for (int i = 0; i < NPIN; i++) begin
        m_dout[i] = 0; m_pud[i] = 0; m_ev[i] = 0; m_ien[i] = 0; m_frc[i] = 0;
        m_edge[i] = 0; m_mode[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0;
      end
    end else begin
      bit nin[NPIN];
      int a, p, off, d;
      a = int'(bus_addr); p = a / 48; off = a % 48; d = int'(bus_wdata);
      for (int i = 0; i < NPIN; i++) begin
        bit cur, trig, clr;
        cur  = m_in(i);
        trig = (m_ctrl & 1) && (cur != m_prev[i]) && (cur == m_edge[i]);
        clr  = bus_sel && bus_wr && a != 0 && p == i / 8 && off == 20 && d[i % 8];
        m_ev[i] = trig || m_frc[i] || (m_ev[i] && !clr);
        nin[i] = cur;
      end
      if (bus_sel && bus_wr) begin
        if (a == 0) m_ctrl = d & 3;
        else if (p < NP)
          for (int k = 0; k < 8; k++) begin
            int i;
            i = p * 8 + k;
            case (off)
              8:  m_dout[i] = d[k];
              12: m_mode[i] = (d >> (2 * k)) & 3;
              16: m_pud[i]  = d[k];
              24: m_ien[i]  = d[k];
              28: m_frc[i]  = d[k];
              32: m_edge[i] = d[k];
              default: ;
            endcase
          end
      end
      for (int i = 0; i < NPIN; i++) begin
        m_prev[i] = nin[i];
        m_s2[i] = m_s1[i];
        m_s1[i] = pad_in[i];
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      for (int i = 0; i < NPIN; i++) begin
        bit oe, ov;
        case (m_mode[i])
          1: begin oe = 1; ov = m_dout[i]; end
          2: begin oe = !m_dout[i]; ov = 0; end
          3: begin oe = m_dout[i]; ov = 1; end
          default: begin oe = 0; ov = 0; end
        endcase
        check("R3 pad_oe", 32'(pad_oe[i]), 32'(oe));
        check("R3 pad_out", 32'(pad_out[i]), 32'(ov));
        check("R4 pad_pu", 32'(pad_pu[i]), 32'(!m_pud[i]));
      end
      for (int p = 0; p < NP; p++) begin
        bit e;
        e = 0;
        for (int k = 0; k < 8; k++) e = e | (m_ev[p*8+k] & m_ien[p*8+k]);
        check("R9 irq", 32'(port_irq[p]), 32'(e));
      end
      if (bus_sel && !bus_wr) check("R2 rdata", bus_rdata, 32'(m_read(int'(bus_addr))));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = 32'(d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
    #3 v = bus_rdata;
  endtask

  task automatic set_pin(int i, bit v);
    @(negedge clk);
    bus_sel = 0;
    pad_in[i] = v;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    #45 rst_n = 1;
    // R1: reset state
    rd(32'h0C, v); check("R1 mode reset", v, 0);
    check("R1 oe reset", 32'(pad_oe), 0);
    check("R1 pu reset", 32'(pad_pu), 32'((1 << NPIN) - 1));
    check("R1 irq reset", 32'(port_irq), 0);
    // R2: identification word
    rd(0, v); check("R2 ctrl", v, (NP << 9) | (VER << 2));
    wr(0, 1);
    rd(0, v); check("R2 ctrl run", v, (NP << 9) | (VER << 2) | 1);
    // R3: four drive modes
    wr(32'h0C, 32'hE4); wr(32'h08, 32'h0F);
    rd(32'h0C, v); check("R2 mode readback", v, 32'hE4);
    check("R3 oe data1", 32'(pad_oe[3:0]), 4'b1010);
    check("R3 out data1", 32'(pad_out[3:0]), 4'b1010);
    wr(32'h08, 0); idle(1);
    check("R3 oe data0", 32'(pad_oe[3:0]), 4'b0110);
    check("R3 out data0", 32'(pad_out[3:0]), 4'b1000);
    // R4: pull-up disable on port 1
    wr(32'h40, 32'hA5); idle(1);
    check("R4 pull", 32'(pad_pu[15:8]), 32'h5A);
    // R5/R6: single-flop latency, rising edge on pin 8
    wr(32'h50, 1); wr(32'h48, 1);
    set_pin(8, 1);
    rd(32'h44, v); check("R5 ev one cycle", v, 0);
    rd(32'h34, v); check("R5 in one flop", v, 1);
    rd(32'h44, v); check("R6 rising ev", v, 1);
    check("R9 irq set", 32'(port_irq), 3'b010);
    // R6: pin 9 falling-only, interrupt disabled
    set_pin(9, 1); idle(3);
    rd(32'h44, v); check("R6 wrong edge", v, 1);
    set_pin(9, 0); idle(3);
    rd(32'h44, v); check("R6 falling ev", v, 3);
    // R7: write-one-to-clear
    wr(32'h44, 1);
    rd(32'h44, v); check("R7 clear", v, 2);
    check("R9 irq cleared", 32'(port_irq), 0);
    wr(32'h44, 0);
    rd(32'h44, v); check("R7 zero write", v, 2);
    // R5: two-flop latency on pin 16
    wr(0, 3);
    set_pin(16, 1);
    rd(32'h64, v); check("R5 two flop early", v, 0);
    rd(32'h64, v); check("R5 two flop", v, 1);
    idle(2);
    rd(32'h74, v); check("R6 no rise on falling select", v, 0);
    // R8: force register
    wr(32'h7C, 32'h80);
    rd(32'h74, v); check("R8 forced", v, 32'h80);
    wr(32'h74, 32'h80);
    rd(32'h74, v); check("R8 force beats clear", v, 32'h80);
    wr(32'h7C, 0); wr(32'h74, 32'h80);
    rd(32'h74, v); check("R8 force off", v, 0);
    // R6: detection disabled
    wr(0, 2);
    set_pin(8, 0); idle(4); set_pin(8, 1); idle(4);
    rd(32'h44, v); check("R6 run off", v, 2);
    // R10: unmapped and out-of-range
    wr(32'h24, 32'hFF);
    rd(32'h24, v); check("R10 gap read", v, 0);
    wr(32'h98, 32'hFF);
    rd(32'h98, v); check("R10 port beyond count", v, 0);
    rd(32'h08, v); check("R10 no alias", v, 0);
    check("R10 pads unchanged", 32'(pad_oe[7:0]), 32'h06);
    wr(32'h04, 32'hFF);
    rd(32'h04, v); check("R10 input read-only", v, 0);
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule